// File: doc/BRIEF.md
# Shift-Amount Register and Funnel Shifter

This block is a 32-bit shift unit that keeps its shift distance in a dedicated 6-bit amount register. A family of setup operations loads the amount from a source operand, from byte-lane arithmetic on a source operand, or from a 5-bit immediate. The shift operations that follow read the stored amount. They provide a 64-bit funnel right shift across two operands, a logical right shift, an arithmetic right shift and a left shift by 32 minus the amount. Because the register holds 6 bits, a distance of 32 is legal and gives fully defined results.

Each operation is presented with a one-cycle valid strobe. The result and a result-valid flag appear one clock later. An amount loaded by one operation is seen by a shift issued in the very next cycle. Direct read, write and exchange operations give plain access to the amount register. A write keeps only the low 6 bits.

Top module: `shift_unit`

## Requirements
- R1: After reset the amount register reads 0, result_valid_o is 0 and result_o is 0.
- R2: Operation code 1 (set for right shift) loads the amount with src_s_i[4:0].
- R3: Operation code 2 (set for left shift) loads the amount with 32 minus src_s_i[4:0], so a low field of 0 loads 32.
- R4: Operation code 3 loads the amount with src_s_i[1:0] times 8. Operation code 4 loads it with 32 minus src_s_i[1:0] times 8.
- R5: Operation code 5 loads the amount with imm_i, which is 5 bits wide.
- R6: Operation code 7 writes src_s_i[5:0] to the amount. Operation code 6 returns the amount, zero-extended, on result_o. Operation code 8 returns the old amount and writes src_s_i[5:0] in the same operation.
- R7: Operation code 9 returns the low 32 bits of {src_s_i, src_t_i} shifted right by the amount.
- R8: Operation code 10 returns src_t_i shifted right logically by the amount. The result is 0 for any amount of 32 or more.
- R9: Operation code 11 returns src_t_i shifted right arithmetically by the amount. For any amount of 32 or more, every bit equals the sign bit.
- R10: Operation code 12 returns the low 32 bits of src_s_i shifted left by (32 minus the amount) modulo 64. An amount of 32 passes src_s_i through unchanged.
- R11: result_valid_o is high exactly one cycle after valid_i. While valid_i is low, result_o and the amount hold their values. A shift issued in the cycle after a setup uses the new amount.
- R12: Operation codes 0 and 13 to 15 leave the amount unchanged. Those codes, and codes 1 to 5 and 7, return a result of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 4 | Operation code |
| src_s_i | input | 32 | First operand (setup source, funnel upper half, left-shift data) |
| src_t_i | input | 32 | Second operand (funnel lower half, right-shift data) |
| imm_i | input | 5 | Immediate shift amount |
| result_o | output | 32 | Registered result |
| result_valid_o | output | 1 | Result valid, one cycle after valid_i |
| sar_o | output | 6 | Current amount register value |

## Verification
The bench builds the unit with its default 32-bit data width, which makes the amount register 6 bits. With that width all 64 amount values can be written directly. Every shift operation is swept across the whole amount range, including 32 and the out-of-range values 33 to 63, on several operand patterns. Every possible low source field is applied to each setup operation, and every immediate value is applied as well.

// File: rtl/shu_pkg.sv
package shu_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_NOP      = 4'd0,
    OP_SET_R    = 4'd1,
    OP_SET_L    = 4'd2,
    OP_SET_BLE  = 4'd3,
    OP_SET_BBE  = 4'd4,
    OP_SET_IMM  = 4'd5,
    OP_AMT_RD   = 4'd6,
    OP_AMT_WR   = 4'd7,
    OP_AMT_SWAP = 4'd8,
    OP_FUNNEL   = 4'd9,
    OP_SRL      = 4'd10,
    OP_SRA      = 4'd11,
    OP_SLL      = 4'd12,
    OP_RSV13    = 4'd13,
    OP_RSV14    = 4'd14,
    OP_RSV15    = 4'd15
  } shu_op_e;
endpackage

// File: rtl/shu_amount_reg.sv
module shu_amount_reg
  import shu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        valid_i,
  input  shu_op_e                     op_i,
  input  logic [DATA_W-1:0]           src_i,
  input  logic [$clog2(DATA_W)-1:0]   imm_i,
  output logic [$clog2(DATA_W):0]     amt_o
);
  localparam int SHW = $clog2(DATA_W);
  localparam int AW  = SHW + 1;
  localparam int BSW = $clog2(DATA_W / 8);

  logic [AW-1:0] amt_q, amt_d;
  logic          load_en;

  function automatic logic [AW-1:0] fn_left_amt(input logic [SHW-1:0] f);
    return AW'(DATA_W) - AW'(f);
  endfunction

  function automatic logic [AW-1:0] fn_byte_amt(input logic [BSW-1:0] b);
    return AW'({b, 3'b000});
  endfunction

  always_comb begin
    load_en = valid_i;
    amt_d   = amt_q;
    unique case (op_i)
      OP_SET_R:    amt_d = AW'(src_i[SHW-1:0]);
      OP_SET_L:    amt_d = fn_left_amt(src_i[SHW-1:0]);
      OP_SET_BLE:  amt_d = fn_byte_amt(src_i[BSW-1:0]);
      OP_SET_BBE:  amt_d = AW'(DATA_W) - fn_byte_amt(src_i[BSW-1:0]);
      OP_SET_IMM:  amt_d = AW'(imm_i);
      OP_AMT_WR,
      OP_AMT_SWAP: amt_d = src_i[AW-1:0];
      default:     load_en = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       amt_q <= '0;
    else if (load_en) amt_q <= amt_d;
  end

  assign amt_o = amt_q;

  assert_set_right_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == OP_SET_R) |=> amt_q == AW'($past(src_i[SHW-1:0])));

  assert_set_left_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == OP_SET_L) |=> (amt_q != '0 && amt_q <= AW'(DATA_W)));

  assert_write_low_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == OP_AMT_WR) |=> amt_q == $past(src_i[AW-1:0]));

  assert_amt_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_i || op_i == OP_NOP || op_i == OP_AMT_RD || op_i >= OP_FUNNEL)
      |=> $stable(amt_q));
endmodule

// File: rtl/shu_shifter.sv
module shu_shifter
  import shu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  shu_op_e                   op_i,
  input  logic [DATA_W-1:0]         src_s_i,
  input  logic [DATA_W-1:0]         src_t_i,
  input  logic [$clog2(DATA_W):0]   amt_i,
  output logic [DATA_W-1:0]         res_o
);
  localparam int AW = $clog2(DATA_W) + 1;
  localparam int WW = 2 * DATA_W;

  logic [AW-1:0] left_amt;

  function automatic logic [DATA_W-1:0] fn_funnel(
    input logic [DATA_W-1:0] hi, input logic [DATA_W-1:0] lo,
    input logic [AW-1:0] n);
    logic [WW-1:0] w;
    w = {hi, lo} >> n;
    return w[DATA_W-1:0];
  endfunction

  function automatic logic [DATA_W-1:0] fn_arith(
    input logic [DATA_W-1:0] v, input logic [AW-1:0] n);
    logic signed [WW-1:0] w;
    w = $signed({{DATA_W{v[DATA_W-1]}}, v}) >>> n;
    return w[DATA_W-1:0];
  endfunction

  function automatic logic [DATA_W-1:0] fn_left(
    input logic [DATA_W-1:0] v, input logic [AW-1:0] n);
    logic [WW-1:0] w;
    w = {{DATA_W{1'b0}}, v} << n;
    return w[DATA_W-1:0];
  endfunction

  assign left_amt = AW'(DATA_W) - amt_i;

  always_comb begin
    unique case (op_i)
      OP_FUNNEL:   res_o = fn_funnel(src_s_i, src_t_i, amt_i);
      OP_SRL:      res_o = fn_funnel('0, src_t_i, amt_i);
      OP_SRA:      res_o = fn_arith(src_t_i, amt_i);
      OP_SLL:      res_o = fn_left(src_s_i, left_amt);
      OP_AMT_RD,
      OP_AMT_SWAP: res_o = DATA_W'(amt_i);
      default:     res_o = '0;
    endcase
  end
endmodule

// File: rtl/shift_unit.sv
module shift_unit
  import shu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       valid_i,
  input  logic [OP_W-1:0]            op_i,
  input  logic [DATA_W-1:0]          src_s_i,
  input  logic [DATA_W-1:0]          src_t_i,
  input  logic [$clog2(DATA_W)-1:0]  imm_i,
  output logic [DATA_W-1:0]          result_o,
  output logic                       result_valid_o,
  output logic [$clog2(DATA_W):0]    sar_o
);
  localparam int AW = $clog2(DATA_W) + 1;

  shu_op_e           op;
  logic [AW-1:0]     amt;
  logic [DATA_W-1:0] shift_res;
  logic [DATA_W-1:0] result_q;
  logic              rvalid_q;

  assign op = shu_op_e'(op_i);

  shu_amount_reg #(.DATA_W(DATA_W)) u_amt (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid_i (valid_i),
    .op_i    (op),
    .src_i   (src_s_i),
    .imm_i   (imm_i),
    .amt_o   (amt)
  );

  shu_shifter #(.DATA_W(DATA_W)) u_shf (
    .op_i    (op),
    .src_s_i (src_s_i),
    .src_t_i (src_t_i),
    .amt_i   (amt),
    .res_o   (shift_res)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result_q <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= valid_i;
      if (valid_i) result_q <= shift_res;
    end
  end

  assign result_o       = result_q;
  assign result_valid_o = rvalid_q;
  assign sar_o          = amt;

  assert_funnel_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op == OP_FUNNEL && amt == '0) |=> result_o == $past(src_t_i));

  assert_srl_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op == OP_SRL && amt >= AW'(DATA_W)) |=> result_o == '0);

  assert_sll_pass_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op == OP_SLL && amt == AW'(DATA_W)) |=> result_o == $past(src_s_i));

  assert_rvalid_rise_R11: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |=> result_valid_o);

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> (!result_valid_o && $stable(result_o)));
endmodule

// File: tb/shift_unit_test.sv
module shift_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [3:0]  op_i = '0;
  logic [31:0] src_s_i = '0;
  logic [31:0] src_t_i = '0;
  logic [4:0]  imm_i = '0;
  logic [31:0] result_o;
  logic        result_valid_o;
  logic [5:0]  sar_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  shift_unit uut (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i),
    .src_s_i(src_s_i), .src_t_i(src_t_i), .imm_i(imm_i),
    .result_o(result_o), .result_valid_o(result_valid_o), .sar_o(sar_o)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic issue(input logic [3:0] op, input logic [31:0] s,
                       input logic [31:0] t, input logic [4:0] im);
    @(negedge clk);
    op_i = op; src_s_i = s; src_t_i = t; imm_i = im; valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  function automatic logic [31:0] ref_srl(input logic [31:0] t, input int n);
    return (n >= 32) ? 32'd0 : t >> n;
  endfunction
  function automatic logic [31:0] ref_sra(input logic [31:0] t, input int n);
    if (n >= 32) return {32{t[31]}};
    return $unsigned($signed(t) >>> n);
  endfunction
  function automatic logic [31:0] ref_funnel(input logic [31:0] s, input logic [31:0] t, input int n);
    if (n >= 32) return s >> (n - 32);
    if (n == 0) return t;
    return (t >> n) | (s << (32 - n));
  endfunction
  function automatic logic [31:0] ref_sll(input logic [31:0] s, input int a);
    int m;
    m = (32 - a) & 63;
    return (m >= 32) ? 32'd0 : s << m;
  endfunction

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    logic [31:0] pat_s [4];
    logic [31:0] pat_t [4];
    logic [31:0] hold;
    pat_s[0] = 32'hDEADBEEF; pat_t[0] = 32'h12345678;
    pat_s[1] = 32'h00000001; pat_t[1] = 32'h80000001;
    pat_s[2] = 32'hFFFFFFFF; pat_t[2] = 32'h7FFFFFFF;
    pat_s[3] = 32'hA5A55A5A; pat_t[3] = 32'hF0F00F0F;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 amount after reset", 32'(sar_o), 32'd0);
    chk("R1 valid after reset", 32'(result_valid_o), 32'd0);
    chk("R1 result after reset", result_o, 32'd0);

    // R2, R3: every low field, with noise in the upper bits
    for (int v = 0; v < 32; v++) begin
      issue(4'd1, 32'hFFFFFFE0 | 32'(v), 32'h0, 5'd0);
      chk("R2 set-right amount", 32'(sar_o), 32'(v));
      chk("R12 setup result zero", result_o, 32'd0);
      issue(4'd2, 32'h5A5A5A40 | 32'(v), 32'h0, 5'd0);
      chk("R3 set-left amount", 32'(sar_o), 32'(32 - v));
    end

    // R4 byte-lane setups
    for (int b = 0; b < 8; b++) begin
      issue(4'd3, 32'hCAFE0000 | 32'(b), 32'h0, 5'd0);
      chk("R4 byte little-endian amount", 32'(sar_o), 32'((b & 3) * 8));
      issue(4'd4, 32'hCAFE0000 | 32'(b), 32'h0, 5'd0);
      chk("R4 byte big-endian amount", 32'(sar_o), 32'(32 - (b & 3) * 8));
    end

    // R5 immediate
    for (int v = 0; v < 32; v++) begin
      issue(4'd5, 32'hFFFFFFFF, 32'h0, 5'(v));
      chk("R5 immediate amount", 32'(sar_o), 32'(v));
    end

    // R6 read, swap
    issue(4'd7, 32'hFFFFFFE9, 32'h0, 5'd0);
    chk("R6 write keeps six bits", 32'(sar_o), 32'd41);
    issue(4'd6, 32'h0, 32'h0, 5'd0);
    chk("R6 read returns amount", result_o, 32'd41);
    chk("R6 read leaves amount", 32'(sar_o), 32'd41);
    issue(4'd8, 32'h00000107, 32'h0, 5'd0);
    chk("R6 swap returns old", result_o, 32'd41);
    chk("R6 swap writes new", 32'(sar_o), 32'd7);

    // R7..R10 sweep over every amount
    for (int n = 0; n < 64; n++) begin
      issue(4'd7, 32'hFFFFFFC0 | 32'(n), 32'h0, 5'd0);
      chk("R6 direct write", 32'(sar_o), 32'(n));
      for (int p = 0; p < 4; p++) begin
        issue(4'd9, pat_s[p], pat_t[p], 5'd0);
        chk("R7 funnel", result_o, ref_funnel(pat_s[p], pat_t[p], n));
        issue(4'd10, pat_s[p], pat_t[p], 5'd0);
        chk("R8 logical right", result_o, ref_srl(pat_t[p], n));
        issue(4'd11, pat_s[p], pat_t[p], 5'd0);
        chk("R9 arithmetic right", result_o, ref_sra(pat_t[p], n));
        issue(4'd12, pat_s[p], pat_t[p], 5'd0);
        chk("R10 left", result_o, ref_sll(pat_s[p], n));
      end
      chk("R12 shifts keep amount", 32'(sar_o), 32'(n));
    end

    // R11 back-to-back setup then shift
    @(negedge clk);
    op_i = 4'd2; src_s_i = 32'd4; valid_i = 1'b1;
    @(negedge clk);
    op_i = 4'd12; src_s_i = 32'h0000_00F1; valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
    chk("R11 shift sees new amount", result_o, 32'h0000_0F10);
    chk("R11 valid after strobe", 32'(result_valid_o), 32'd1);
    hold = result_o;
    @(negedge clk);
    chk("R11 valid drops when idle", 32'(result_valid_o), 32'd0);
    op_i = 4'd1; src_s_i = 32'd9;
    repeat (2) @(negedge clk);
    chk("R11 result held when idle", result_o, hold);
    chk("R11 amount held when idle", 32'(sar_o), 32'd28);

    // R12 NOP and reserved codes
    for (int oc = 13; oc < 17; oc++) begin
      issue((oc == 16) ? 4'd0 : 4'(oc), 32'h0000003F, 32'hFFFFFFFF, 5'd3);
      chk("R12 no-effect amount", 32'(sar_o), 32'd28);
      chk("R12 no-effect result", result_o, 32'd0);
    end

    done = 1'b1;
    finish_run();
  end
endmodule